// File: doc/BRIEF.md
# Base-Point Mixed Addition Sequencer

This block adds a fixed affine base point G to a point P held in Jacobian projective coordinates (X, Y, Z) over a prime field. The sum R comes out in Jacobian coordinates. The prime q, the base point (Gx, Gy) and a precomputed double of the base point (Hx, Hy) are inputs. All of them are sampled together with P on a start pulse.

Internally, a fixed schedule of 21 field operations runs over a small register file. The schedule uses a one-cycle modular add/subtract/copy unit and a bit-serial modular multiplier. A squaring first copies its operand into a scratch register, so that the multiplier never takes both inputs from the same register.

When the schedule ends, a selection stage replaces the computed sum in three cases:
- P is at infinity.
- P equals G.
- P equals the negative of G.

The number of cycles is the same for every operand set. All inputs must be below q, and q must be an odd prime with 3 <= q < 2^W.

Top module: `base_point_adder`

## Requirements
- R1: After reset, done_o is 0 and rx_o, ry_o and rz_o are 0.
- R2: A start_i seen high at a rising edge while idle begins a run. done_o goes high after exactly 11*W+34 rising edges, counting the start edge. The count is the same for every operand value and every special case.
- R3: done_o is high for exactly one cycle per run. rx_o, ry_o and rz_o change only in the cycle in which done_o rises, and they hold their values until the next completion.
- R4: With Z != 0, define A = Z^2*Gx - X and B = Z^3*Gy - Y (mod q), with A != 0. The result is Rz = Z*A and Rx = B^2 - 2*X*A^2 - A^3. It is also Ry = B*(X*A^2 - Rx) - Y*A^3. All arithmetic is modulo q.
- R5: With Z = 0, the result is (Gx, Gy, 1). This case takes priority over every other case, including one where X and Y would make A and B zero.
- R6: With Z != 0, A = 0 and B = 0 (P equals G), the result is (Hx, Hy, 1).
- R7: With Z != 0, A = 0 and B != 0 (P equals -G), the result is the point at infinity, encoded as (1, 1, 0).
- R8: Every completed rx_o, ry_o and rz_o is below q, and so is every internal intermediate value.
- R9: While a run is in progress, start_i is ignored. Changes on the operand inputs also have no effect: the result and the completion cycle are those of the operands sampled at the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| q_i | input | W | Field prime |
| px_i | input | W | Jacobian X of P |
| py_i | input | W | Jacobian Y of P |
| pz_i | input | W | Jacobian Z of P |
| gx_i | input | W | Affine x of base point G |
| gy_i | input | W | Affine y of base point G |
| hx_i | input | W | Affine x of 2G |
| hy_i | input | W | Affine y of 2G |
| done_o | output | 1 | One-cycle completion pulse |
| rx_o | output | W | Jacobian X of result |
| ry_o | output | W | Jacobian Y of result |
| rz_o | output | W | Jacobian Z of result |

## Verification
The bench covers several operand sets:
- General points, including operands at q-1 and a second, small prime. Here a wrong operand route or a wrong subtraction wrap would give a wrong Rx or Ry.
- P equal to G and P equal to -G, both unscaled and scaled by a nonzero Z. A design that captured the zero flags at the wrong step would return the computed sum instead of 2G or infinity.
- Z = 0 with X = Y = 0. A design with the wrong priority would return 2G instead of G.

A second start pulse and changed operands in the middle of a run check that a design which restarts or resamples would shift the completion cycle or change the result. Completion is compared every cycle, so a latency that depends on the operands shows up as an early or late pulse.

// File: rtl/padd_pkg.sv
package padd_pkg;
  typedef enum logic [1:0] {OP_CPY, OP_ADD, OP_SUB, OP_MUL} op_e;
  typedef enum logic [3:0] {
    RG_X, RG_Y, RG_Z, RG_GX, RG_GY, RG_T1, RG_T2, RG_T3, RG_T4, RG_RX, RG_RY, RG_RZ
  } reg_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FINAL} st_e;
  typedef struct packed {
    op_e  op;
    reg_e dst;
    reg_e a;
    reg_e b;
  } step_t;
  localparam int NUM_REGS  = 12;
  localparam int NUM_STEPS = 21;
  localparam int FLAG_STEP = 6;  // second subtraction: zero flags taken here
endpackage

// File: rtl/padd_sched.sv
module padd_sched
  import padd_pkg::*;
#(
  parameter int PCW = 5
) (
  input  logic [PCW-1:0] idx_i,
  output step_t          step_o
);
  always_comb begin
    case (int'(idx_i))
      0:       step_o = '{OP_CPY, RG_T1, RG_Z,  RG_Z};
      1:       step_o = '{OP_MUL, RG_T1, RG_Z,  RG_T1};
      2:       step_o = '{OP_MUL, RG_T2, RG_Z,  RG_T1};
      3:       step_o = '{OP_MUL, RG_T1, RG_T1, RG_GX};
      4:       step_o = '{OP_MUL, RG_T2, RG_T2, RG_GY};
      5:       step_o = '{OP_SUB, RG_T1, RG_T1, RG_X};
      6:       step_o = '{OP_SUB, RG_T2, RG_T2, RG_Y};
      7:       step_o = '{OP_MUL, RG_RZ, RG_Z,  RG_T1};
      8:       step_o = '{OP_CPY, RG_T3, RG_T1, RG_T1};
      9:       step_o = '{OP_MUL, RG_T3, RG_T1, RG_T3};
      10:      step_o = '{OP_MUL, RG_T4, RG_T1, RG_T3};
      11:      step_o = '{OP_MUL, RG_T3, RG_X,  RG_T3};
      12:      step_o = '{OP_ADD, RG_T1, RG_T3, RG_T3};
      13:      step_o = '{OP_CPY, RG_RX, RG_T2, RG_T2};
      14:      step_o = '{OP_MUL, RG_RX, RG_RX, RG_T2};
      15:      step_o = '{OP_SUB, RG_RX, RG_RX, RG_T1};
      16:      step_o = '{OP_SUB, RG_RX, RG_RX, RG_T4};
      17:      step_o = '{OP_SUB, RG_T3, RG_T3, RG_RX};
      18:      step_o = '{OP_MUL, RG_T3, RG_T2, RG_T3};
      19:      step_o = '{OP_MUL, RG_T4, RG_Y,  RG_T4};
      20:      step_o = '{OP_SUB, RG_RY, RG_T3, RG_T4};
      default: step_o = '{OP_CPY, RG_T1, RG_T1, RG_T1};
    endcase
  end
endmodule

// File: rtl/padd_alu.sv
module padd_alu
  import padd_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] q_i,
  output logic [W-1:0] y_o
);
  logic [W:0] sum, dif;
  always_comb begin
    sum = {1'b0, a_i} + {1'b0, b_i};
    dif = (a_i >= b_i) ? ({1'b0, a_i} - {1'b0, b_i})
                       : ({1'b0, a_i} + {1'b0, q_i} - {1'b0, b_i});
    case (op_i)
      OP_ADD:  y_o = (sum >= {1'b0, q_i}) ? W'(sum - {1'b0, q_i}) : W'(sum);
      OP_SUB:  y_o = W'(dif);
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/padd_mulser.sv
module padd_mulser #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] q_i,
  output logic         vld_o,
  output logic [W-1:0] res_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  a_sh, b_r, acc, acc_nx;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [W:0]    dbl, dbl_r, sum;

  // MSB-first interleaved multiply: acc = 2*acc + a_bit*b, reduced twice per step
  always_comb begin
    dbl    = {acc, 1'b0};
    dbl_r  = (dbl >= {1'b0, q_i}) ? (dbl - {1'b0, q_i}) : dbl;
    sum    = dbl_r + (a_sh[W-1] ? {1'b0, b_r} : '0);
    acc_nx = (sum >= {1'b0, q_i}) ? W'(sum - {1'b0, q_i}) : W'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sh  <= '0;
      b_r   <= '0;
      acc   <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (go_i) begin
        a_sh <= a_i;
        b_r  <= b_i;
        acc  <= '0;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        acc  <= acc_nx;
        a_sh <= a_sh << 1;
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy  <= 1'b0;
          vld_o <= 1'b1;
        end
      end
    end
  end

  assign res_o = acc;

  AST_MUL_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy);  // R2
  AST_MUL_REDUCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> res_o < q_i);  // R8
endmodule

// File: rtl/base_point_adder.sv
module base_point_adder
  import padd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] px_i,
  input  logic [W-1:0] py_i,
  input  logic [W-1:0] pz_i,
  input  logic [W-1:0] gx_i,
  input  logic [W-1:0] gy_i,
  input  logic [W-1:0] hx_i,
  input  logic [W-1:0] hy_i,
  output logic         done_o,
  output logic [W-1:0] rx_o,
  output logic [W-1:0] ry_o,
  output logic [W-1:0] rz_o
);
  localparam int PCW = $clog2(NUM_STEPS);
  localparam logic [PCW-1:0] LAST_PC = PCW'(NUM_STEPS - 1);
  localparam logic [PCW-1:0] FLAG_PC = PCW'(FLAG_STEP);

  st_e           st;
  logic [W-1:0]  rf [NUM_REGS];
  logic [W-1:0]  hx_r, hy_r, q_r;
  logic [PCW-1:0] pc;
  logic          mul_issued, z_zero, t1_zero, t2_zero;
  step_t         cur;
  logic [W-1:0]  opa, opb, alu_y, mul_res, wr_data;
  logic          mul_go, mul_vld, wr_en;

  padd_sched #(.PCW(PCW)) u_sched (.idx_i(pc), .step_o(cur));

  assign opa = rf[cur.a];
  assign opb = rf[cur.b];

  padd_alu #(.W(W)) u_alu (
    .op_i(cur.op), .a_i(opa), .b_i(opb), .q_i(q_r), .y_o(alu_y)
  );

  assign mul_go = (st == ST_RUN) && (cur.op == OP_MUL) && !mul_issued;

  padd_mulser #(.W(W)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(mul_go), .a_i(opa), .b_i(opb),
    .q_i(q_r), .vld_o(mul_vld), .res_o(mul_res)
  );

  assign wr_en   = (st == ST_RUN) && ((cur.op != OP_MUL) || mul_vld);
  assign wr_data = (cur.op == OP_MUL) ? mul_res : alu_y;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_IDLE;
      for (int i = 0; i < NUM_REGS; i++) rf[i] <= '0;
      hx_r       <= '0;
      hy_r       <= '0;
      q_r        <= '0;
      pc         <= '0;
      mul_issued <= 1'b0;
      z_zero     <= 1'b0;
      t1_zero    <= 1'b0;
      t2_zero    <= 1'b0;
      done_o     <= 1'b0;
      rx_o       <= '0;
      ry_o       <= '0;
      rz_o       <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          rf[RG_X]   <= px_i;
          rf[RG_Y]   <= py_i;
          rf[RG_Z]   <= pz_i;
          rf[RG_GX]  <= gx_i;
          rf[RG_GY]  <= gy_i;
          hx_r       <= hx_i;
          hy_r       <= hy_i;
          q_r        <= q_i;
          z_zero     <= (pz_i == '0);
          pc         <= '0;
          mul_issued <= 1'b0;
          st         <= ST_RUN;
        end
        ST_RUN: begin
          if (mul_go) mul_issued <= 1'b1;
          if (wr_en) begin
            rf[cur.dst] <= wr_data;
            mul_issued  <= 1'b0;
            if (pc == FLAG_PC) begin
              t1_zero <= (rf[RG_T1] == '0);
              t2_zero <= (wr_data == '0);
            end
            if (pc == LAST_PC) st <= ST_FINAL;
            else pc <= pc + 1'b1;
          end
        end
        ST_FINAL: begin
          // selection after the full schedule keeps the run length fixed
          if (z_zero) begin
            rx_o <= rf[RG_GX]; ry_o <= rf[RG_GY]; rz_o <= W'(1);
          end else if (t1_zero && t2_zero) begin
            rx_o <= hx_r; ry_o <= hy_r; rz_o <= W'(1);
          end else if (t1_zero) begin
            rx_o <= W'(1); ry_o <= W'(1); rz_o <= '0;
          end else begin
            rx_o <= rf[RG_RX]; ry_o <= rf[RG_RY]; rz_o <= rf[RG_RZ];
          end
          done_o <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R3
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(rx_o) && $stable(ry_o) && $stable(rz_o)));  // R3
  AST_OUT_REDUCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rx_o < q_r && ry_o < q_r && rz_o < q_r));  // R8
  AST_WB_REDUCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> wr_data < q_r);  // R8
  AST_INF_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && rz_o == '0) |-> (rx_o == W'(1) && ry_o == W'(1)));  // R7
  AST_G_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && z_zero) |-> (rx_o == rf[RG_GX] && ry_o == rf[RG_GY] && rz_o == W'(1)));  // R5
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RUN && start_i && !(wr_en && pc == LAST_PC)) |=> st == ST_RUN);  // R9
endmodule

// File: tb/base_point_adder_test.sv
`timescale 1ns/1ps
module base_point_adder_test;
  localparam int W   = 16;
  localparam int LAT = 11 * W + 34;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] q, px, py, pz, gx, gy, hx, hy;
  logic         done;
  logic [W-1:0] rx, ry, rz;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] prev_x = '0, prev_y = '0, prev_z = '0;

  always #2.5 clk = ~clk;

  base_point_adder #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .q_i(q),
    .px_i(px), .py_i(py), .pz_i(pz), .gx_i(gx), .gy_i(gy), .hx_i(hx), .hy_i(hy),
    .done_o(done), .rx_o(rx), .ry_o(ry), .rz_o(rz)
  );

  function automatic longint mm(longint a, longint b, longint m);
    return (a * b) % m;
  endfunction
  function automatic longint ma(longint a, longint b, longint m);
    return (a + b) % m;
  endfunction
  function automatic longint ms(longint a, longint b, longint m);
    return (a - b + m) % m;
  endfunction

  task automatic ref_add(input longint m, x, y, z, ggx, ggy, hhx, hhy,
                         output longint ex, ey, ez);
    longint a, b, a2, a3, xa2;
    a = ms(mm(mm(z, z, m), ggx, m), x, m);
    b = ms(mm(mm(mm(z, z, m), z, m), ggy, m), y, m);
    if (z == 0) begin ex = ggx; ey = ggy; ez = 1; end
    else if (a == 0 && b == 0) begin ex = hhx; ey = hhy; ez = 1; end
    else if (a == 0) begin ex = 1; ey = 1; ez = 0; end
    else begin
      a2  = mm(a, a, m);
      a3  = mm(a, a2, m);
      xa2 = mm(x, a2, m);
      ez  = mm(z, a, m);
      ex  = ms(ms(mm(b, b, m), ma(xa2, xa2, m), m), a3, m);
      ey  = ms(mm(b, ms(xa2, ex, m), m), mm(y, a3, m), m);
    end
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input longint m, x, y, z, ggx, ggy, hhx, hhy,
                     input bit poke);
    longint ex, ey, ez;
    int n;
    ref_add(m, x, y, z, ggx, ggy, hhx, hhy, ex, ey, ez);
    @(negedge clk);
    q = W'(m); px = W'(x); py = W'(y); pz = W'(z);
    gx = W'(ggx); gy = W'(ggy); hx = W'(hhx); hy = W'(hhy);
    start = 1'b1;
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (poke && n == 50) begin  // R9: mid-run start and operand changes
        start = 1'b1;
        px = px ^ 16'h0055; pz = '0; gx = gx + 1'b1;
      end
      chk({tag, " R2 done timing"}, longint'(done), longint'(n == LAT));
      if (n < LAT) begin
        if (n % 40 == 0) begin  // R3 hold while running
          chk({tag, " R3 hold x"}, rx, prev_x);
          chk({tag, " R3 hold z"}, rz, prev_z);
        end
      end else begin
        chk({tag, " rx"}, rx, ex);
        chk({tag, " ry"}, ry, ey);
        chk({tag, " rz"}, rz, ez);
        chk({tag, " R8 reduced"}, longint'(rx < q && ry < q && rz < q), 1);
        break;
      end
      if (n > LAT + 5) break;
    end
    start = 1'b0;
    @(negedge clk);
    chk({tag, " R3 pulse"}, longint'(done), 0);
    chk({tag, " R3 held y"}, ry, ey);
    prev_x = rx; prev_y = ry; prev_z = rz;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint m, gxv, gyv, hxv, hyv;
    m = 65521; gxv = 1234; gyv = 5678; hxv = 4321; hyv = 8765;
    q = '0; px = '0; py = '0; pz = '0; gx = '0; gy = '0; hx = '0; hy = '0;
    repeat (3) @(negedge clk);
    chk("R1 done", longint'(done), 0);
    chk("R1 rx", rx, 0);
    chk("R1 ry", ry, 0);
    chk("R1 rz", rz, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle", longint'(done), 0);

    run("R4 general a", m, 100, 200, 7, gxv, gyv, hxv, hyv, 0);
    run("R4 general near q", m, m - 1, m - 2, m - 1, gxv, gyv, hxv, hyv, 0);
    run("R4 general z1", m, 9999, 31337, 1, gxv, gyv, hxv, hyv, 0);
    run("R4 small prime", 251, 17, 250, 3, 40, 99, 5, 6, 0);
    run("R5 z zero", m, 5, 9, 0, gxv, gyv, hxv, hyv, 0);
    run("R5 z zero xy zero", m, 0, 0, 0, gxv, gyv, hxv, hyv, 0);
    run("R6 p eq g", m, gxv, gyv, 1, gxv, gyv, hxv, hyv, 0);
    run("R6 p eq g scaled", m, mm(gxv, 9, m), mm(gyv, 27, m), 3, gxv, gyv, hxv, hyv, 0);
    run("R7 p eq neg g", m, gxv, m - gyv, 1, gxv, gyv, hxv, hyv, 0);
    run("R7 p eq neg g scaled", m, mm(gxv, 25, m), ms(0, mm(gyv, 125, m), m), 5,
        gxv, gyv, hxv, hyv, 0);
    run("R9 busy start", m, 321, 654, 11, gxv, gyv, hxv, hyv, 1);
    run("R4 after busy", m, 2, 3, 4, gxv, gyv, hxv, hyv, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule